// File: doc/BRIEF.md
# Shadow Region Controller

This block holds the upper-memory shadow configuration of a memory chipset and turns it into routing decisions. Software selects a register by writing its number to an index port, then reads or writes that register through a data port. The register contents decide, for each region above C0000h and for each access type, whether a cycle is served by internal DRAM or passed to the external bus.

The routed area has two parts. Eight 16 KB segments cover C0000h to DFFFFh, and two 64 KB segments cover E0000h and F0000h. Each segment has a read-routing bit and a write-routing bit, and the two are independent. The block exports these bits as vectors. It also answers a combinational routing query for a 20-bit address and a read/write strobe, which a memory decoder in the same cycle can use. It drives two shadow status flags for the BIOS area and an external-cache enable. A one-cycle pulse tells translation caches to flush whenever the routing map is rewritten.

Top module: `shadow_route_ctrl`

## Requirements
- R1: A write strobe with `io_addr` equal to 0022h loads `io_wdata` into the index latch. While `io_addr` is 0022h, `io_rdata` shows the index latch.
- R2: A write strobe with `io_addr` equal to 0024h stores `io_wdata` into the register the index latch names, when that index is 02h, 04h, 05h or 06h. While `io_addr` is 0024h, `io_rdata` shows that register without delay.
- R3: The following return FFh on `io_rdata`: any other index through port 0024h, and any other `io_addr`. Writes to other indices or to other I/O addresses leave every register unchanged.
- R4: After reset, the index and all registers are 00h. Every routing output, flag, the cache enable and the change pulse are 0, so all regions go to the external bus.
- R5: Segment n (n = 0..7) starts at C0000h + n·4000h. Segments 0–3 are controlled by register 04h and segments 4–7 by register 05h. Within that register, bit 2·(n mod 4) set routes reads to internal DRAM (`seg_rd_int[n]`) and bit 2·(n mod 4)+1 set routes writes to internal DRAM (`seg_wr_int[n]`). A cleared bit means the external bus.
- R6: Register 06h controls the two top segments. Bit 0 is the read route and bit 1 the write route for E0000h–EFFFFh (`top_rd_int[0]`, `top_wr_int[0]`). Bit 2 is the read route and bit 3 the write route for F0000h–FFFFFh (`top_rd_int[1]`, `top_wr_int[1]`).
- R7: `bios_shadow_rd` is 1 when register 06h bit 0 or bit 2 is set. `bios_shadow_wr` is 1 when bit 1 or bit 3 is set.
- R8: `ext_cache_en` is 1 only when register 02h bits 2 and 3 are both set.
- R9: For `q_addr` in C0000h–FFFFFh, `q_hit` is 1. `q_internal` then equals the read route of the containing segment when `q_write` is 0, and its write route when `q_write` is 1. Below C0000h, `q_hit` and `q_internal` are 0.
- R10: `map_changed` is 1 for exactly the one cycle after a clock edge that accepted a data-port write with index 04h, 05h or 06h. It stays 0 after writes to 02h, to unused indices, or to the index port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_addr | input | 16 | I/O address of the current access |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for the addressed port |
| q_addr | input | 20 | Memory address of the routing query |
| q_write | input | 1 | Query access type: 1 write, 0 read |
| q_hit | output | 1 | Query address lies in the routed area |
| q_internal | output | 1 | Query access goes to internal DRAM |
| seg_rd_int | output | 8 | Read routes of the eight 16 KB segments |
| seg_wr_int | output | 8 | Write routes of the eight 16 KB segments |
| top_rd_int | output | 2 | Read routes of the E and F 64 KB segments |
| top_wr_int | output | 2 | Write routes of the E and F 64 KB segments |
| bios_shadow_rd | output | 1 | Any top segment read from DRAM |
| bios_shadow_wr | output | 1 | Any top segment written to DRAM |
| ext_cache_en | output | 1 | External cache enable |
| map_changed | output | 1 | One-cycle pulse after a routing register write |

## Verification
The query tests set single route bits, one at a time, in each of the three routing registers. They probe the first byte, the last byte and a middle byte of the target segment and of its neighbours. This separates an error in the bit position (2n mod 4 pairs) from an error in the choice between registers 04h and 05h, or in the split on address bit 16. Each pattern is queried as both a read and a write, which shows that the two routes are independent. Addresses just below C0000h and at zero check the edge of the routed area. Writes to an unused index, and to a port that is neither the index port nor the data port, are followed by read-back and a query, which shows whether any register was disturbed.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned NUM_SEG   = 8;
  localparam int unsigned NUM_TOP   = 2;
  localparam int unsigned SEG_PER_R = DW / 2;
  localparam int unsigned QAW       = 20;

  localparam logic [DW-1:0] IDX_CACHE = 8'h02;
  localparam logic [DW-1:0] IDX_SEGL  = 8'h04;
  localparam logic [DW-1:0] IDX_SEGH  = 8'h05;
  localparam logic [DW-1:0] IDX_TOP   = 8'h06;
  localparam logic [DW-1:0] RD_EMPTY  = 8'hFF;

  typedef struct packed {
    logic [DW-1:0] cache;
    logic [DW-1:0] segl;
    logic [DW-1:0] segh;
    logic [DW-1:0] top;
  } cfg_t;
endpackage

// File: rtl/shr_regfile.sv
module shr_regfile
  import shr_pkg::*;
#(
  parameter int unsigned    IO_AW     = 16,
  parameter logic [IO_AW-1:0] IDX_PORT  = 16'h0022,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  output cfg_t             cfg,
  output logic             map_changed
);
  logic [DW-1:0] idx_q, idx_d;
  cfg_t          cfg_q, cfg_d;
  logic          chg_q, chg_d;
  logic          sel_idx, sel_dat, wr_idx, wr_dat;
  logic          en_cache, en_segl, en_segh, en_top, idx_known;

  always_comb begin
    sel_idx   = (io_addr == IDX_PORT);
    sel_dat   = (io_addr == DATA_PORT);
    wr_idx    = io_wr && sel_idx;
    wr_dat    = io_wr && sel_dat;
    en_cache  = wr_dat && (idx_q == IDX_CACHE);
    en_segl   = wr_dat && (idx_q == IDX_SEGL);
    en_segh   = wr_dat && (idx_q == IDX_SEGH);
    en_top    = wr_dat && (idx_q == IDX_TOP);
    idx_known = (idx_q == IDX_CACHE) || (idx_q == IDX_SEGL) ||
                (idx_q == IDX_SEGH)  || (idx_q == IDX_TOP);
  end

  always_comb begin
    idx_d = idx_q;
    cfg_d = cfg_q;
    if (wr_idx)   idx_d     = io_wdata;
    if (en_cache) cfg_d.cache = io_wdata;
    if (en_segl)  cfg_d.segl  = io_wdata;
    if (en_segh)  cfg_d.segh  = io_wdata;
    if (en_top)   cfg_d.top   = io_wdata;
    chg_d = en_segl || en_segh || en_top;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cfg_q <= '0;
      chg_q <= 1'b0;
    end else begin
      if (wr_idx) idx_q <= idx_d;
      if (wr_dat) cfg_q <= cfg_d;
      chg_q <= chg_d;
    end
  end

  always_comb begin
    io_rdata = RD_EMPTY;
    if (sel_idx) begin
      io_rdata = idx_q;
    end else if (sel_dat) begin
      case (idx_q)
        IDX_CACHE: io_rdata = cfg_q.cache;
        IDX_SEGL:  io_rdata = cfg_q.segl;
        IDX_SEGH:  io_rdata = cfg_q.segh;
        IDX_TOP:   io_rdata = cfg_q.top;
        default:   io_rdata = RD_EMPTY;
      endcase
    end
  end

  assign cfg         = cfg_q;
  assign map_changed = chg_q;

  // R1: index port write lands in the index latch
  p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && sel_idx) |=> (idx_q == $past(io_wdata)));

  // R3: write to an unused index disturbs no register
  p_unimpl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && sel_dat && !idx_known) |=> $stable(cfg_q));

  // R10: the change pulse only follows a routing register write
  p_change_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> $past(wr_dat && (idx_q == IDX_SEGL || idx_q == IDX_SEGH || idx_q == IDX_TOP)));
endmodule

// File: rtl/shr_seg_decode.sv
module shr_seg_decode
  import shr_pkg::*;
(
  input  cfg_t               cfg,
  output logic [NUM_SEG-1:0] seg_rd,
  output logic [NUM_SEG-1:0] seg_wr,
  output logic [NUM_TOP-1:0] top_rd,
  output logic [NUM_TOP-1:0] top_wr
);
  for (genvar n = 0; n < NUM_SEG; n++) begin : g_seg
    localparam int unsigned LO = (2 * n) % DW;
    if (n < SEG_PER_R) begin : g_low
      assign seg_rd[n] = cfg.segl[LO];
      assign seg_wr[n] = cfg.segl[LO+1];
    end else begin : g_high
      assign seg_rd[n] = cfg.segh[LO];
      assign seg_wr[n] = cfg.segh[LO+1];
    end
  end

  for (genvar t = 0; t < NUM_TOP; t++) begin : g_top
    assign top_rd[t] = cfg.top[2*t];
    assign top_wr[t] = cfg.top[2*t+1];
  end
endmodule

// File: rtl/shr_query.sv
module shr_query
  import shr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [QAW-1:0]     q_addr,
  input  logic               q_write,
  input  logic [NUM_SEG-1:0] seg_rd,
  input  logic [NUM_SEG-1:0] seg_wr,
  input  logic [NUM_TOP-1:0] top_rd,
  input  logic [NUM_TOP-1:0] top_wr,
  output logic               q_hit,
  output logic               q_internal
);
  localparam int unsigned SEG_SH = 14;
  localparam int unsigned SEG_IW = $clog2(NUM_SEG);

  logic              upper, in_top;
  logic [SEG_IW-1:0] seg_i;
  logic              top_i;
  logic              unused_low;

  assign unused_low = ^q_addr[SEG_SH-1:0];

  always_comb begin
    upper  = (q_addr[QAW-1:QAW-2] == 2'b11);
    in_top = q_addr[QAW-3];
    seg_i  = q_addr[SEG_SH+SEG_IW-1:SEG_SH];
    top_i  = q_addr[QAW-4];
    q_hit  = upper;
    q_internal = 1'b0;
    if (upper) begin
      if (in_top) q_internal = q_write ? top_wr[top_i] : top_rd[top_i];
      else        q_internal = q_write ? seg_wr[seg_i] : seg_rd[seg_i];
    end
  end

  // R9: addresses below the routed area never reach internal DRAM
  p_outside_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_addr < 20'hC0000) |-> (!q_hit && !q_internal));
endmodule

// File: rtl/shadow_route_ctrl.sv
module shadow_route_ctrl
  import shr_pkg::*;
#(
  parameter int unsigned IO_AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic [19:0]      q_addr,
  input  logic             q_write,
  output logic             q_hit,
  output logic             q_internal,
  output logic [7:0]       seg_rd_int,
  output logic [7:0]       seg_wr_int,
  output logic [1:0]       top_rd_int,
  output logic [1:0]       top_wr_int,
  output logic             bios_shadow_rd,
  output logic             bios_shadow_wr,
  output logic             ext_cache_en,
  output logic             map_changed
);
  cfg_t cfg;
  logic unused_cfg;

  shr_regfile #(.IO_AW(IO_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg(cfg),
    .map_changed(map_changed)
  );

  shr_seg_decode u_dec (
    .cfg(cfg), .seg_rd(seg_rd_int), .seg_wr(seg_wr_int),
    .top_rd(top_rd_int), .top_wr(top_wr_int)
  );

  shr_query u_query (
    .clk(clk), .rst_n(rst_n), .q_addr(q_addr), .q_write(q_write),
    .seg_rd(seg_rd_int), .seg_wr(seg_wr_int),
    .top_rd(top_rd_int), .top_wr(top_wr_int),
    .q_hit(q_hit), .q_internal(q_internal)
  );

  assign bios_shadow_rd = cfg.top[0] | cfg.top[2];
  assign bios_shadow_wr = cfg.top[1] | cfg.top[3];
  assign ext_cache_en   = cfg.cache[2] & cfg.cache[3];
  assign unused_cfg     = ^{cfg.cache[7:4], cfg.cache[1:0], cfg.top[7:4]};

  // R7: flags agree with the decoded top-segment routes
  p_bios_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bios_shadow_rd == (top_rd_int != 2'b00));
  p_bios_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bios_shadow_wr == (top_wr_int != 2'b00));
endmodule

// File: tb/tb_shadow_route_ctrl.sv
`timescale 1ns/1ps
module tb_shadow_route_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [19:0] q_addr = 20'h00000;
  logic        q_write = 1'b0;
  logic        q_hit, q_internal;
  logic [7:0]  seg_rd_int, seg_wr_int;
  logic [1:0]  top_rd_int, top_wr_int;
  logic        bios_shadow_rd, bios_shadow_wr, ext_cache_en, map_changed;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [15:0] PI = 16'h0022;
  localparam logic [15:0] PD = 16'h0024;

  // {index, data, query address, write, expected hit, expected internal}
  localparam int NV = 15;
  localparam logic [38:0] VEC [NV] = '{
    {8'h04, 8'h01, 20'hC0000, 1'b0, 1'b1, 1'b1},
    {8'h04, 8'h01, 20'hC0000, 1'b1, 1'b1, 1'b0},
    {8'h04, 8'h08, 20'hC4000, 1'b1, 1'b1, 1'b1},
    {8'h04, 8'h08, 20'hC0000, 1'b0, 1'b1, 1'b0},
    {8'h05, 8'h40, 20'hDC000, 1'b0, 1'b1, 1'b1},
    {8'h05, 8'h40, 20'hDBFFF, 1'b0, 1'b1, 1'b0},
    {8'h05, 8'h04, 20'hD7FFF, 1'b0, 1'b1, 1'b1},
    {8'h06, 8'h02, 20'hEFFFF, 1'b1, 1'b1, 1'b1},
    {8'h06, 8'h02, 20'hE0000, 1'b0, 1'b1, 1'b0},
    {8'h06, 8'h04, 20'hFFFF0, 1'b0, 1'b1, 1'b1},
    {8'h06, 8'h04, 20'hF0000, 1'b1, 1'b1, 1'b0},
    {8'h06, 8'h0F, 20'hBFFFF, 1'b0, 1'b0, 1'b0},
    {8'h04, 8'hFF, 20'h00000, 1'b1, 1'b0, 1'b0},
    {8'h04, 8'hFF, 20'hCC000, 1'b1, 1'b1, 1'b1},
    {8'h07, 8'h00, 20'hCC000, 1'b0, 1'b1, 1'b1}
  };

  shadow_route_ctrl dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .q_addr(q_addr),
    .q_write(q_write), .q_hit(q_hit), .q_internal(q_internal),
    .seg_rd_int(seg_rd_int), .seg_wr_int(seg_wr_int),
    .top_rd_int(top_rd_int), .top_wr_int(top_wr_int),
    .bios_shadow_rd(bios_shadow_rd), .bios_shadow_wr(bios_shadow_wr),
    .ext_cache_en(ext_cache_en), .map_changed(map_changed)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h, want %0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, the rising edge in between takes the write
  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    io_addr = a;
    #1;
    d = io_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: reset state
    io_read(PI, rd);  chk("R4 index", rd, 8'h00);
    io_write(PI, 8'h04);
    io_read(PD, rd);  chk("R4 reg04", rd, 8'h00);
    chk("R4 routes", {seg_rd_int, seg_wr_int, top_rd_int, top_wr_int}, 0);
    chk("R4 flags", {bios_shadow_rd, bios_shadow_wr, ext_cache_en, map_changed}, 0);
    q_addr = 20'hF8000; #1;
    chk("R4 query", {q_hit, q_internal}, 2'b10);

    // R1: index latch and readback
    io_write(PI, 8'h5A);
    io_read(PI, rd);  chk("R1 index readback", rd, 8'h5A);
    // R3: unused index reads FFh
    io_read(PD, rd);  chk("R3 unused index read", rd, 8'hFF);
    io_read(16'h0023, rd); chk("R3 other port read", rd, 8'hFF);

    // R2/R8: register 02h and cache enable
    io_write(PI, 8'h02);
    io_write(PD, 8'h0C);
    chk("R10 no pulse for 02h", map_changed, 1'b0);
    io_read(PD, rd);  chk("R2 reg02 readback", rd, 8'h0C);
    chk("R8 both bits", ext_cache_en, 1'b1);
    io_write(PD, 8'h04);
    chk("R8 one bit", ext_cache_en, 1'b0);
    io_write(PD, 8'hF8);
    chk("R8 other bit", ext_cache_en, 1'b0);

    // R9/R5/R6: vector table
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      io_write(PI, v[38:31]);
      io_write(PD, v[30:23]);
      q_addr = v[22:3]; q_write = v[2];
      #1;
      chk($sformatf("R9 vec %0d hit", i), q_hit, v[1]);
      chk($sformatf("R9 vec %0d internal", i), q_internal, v[0]);
    end

    // R5/R6: exported route vectors after the table (04=FF, 05=04, 06=0F)
    chk("R5 seg read routes", seg_rd_int, 8'h2F);
    chk("R5 seg write routes", seg_wr_int, 8'h0F);
    chk("R6 top routes", {top_rd_int, top_wr_int}, 4'hF);
    // R3: the unused-index write left register 04h intact, stray port write too
    io_write(16'h0023, 8'h00);
    io_write(PI, 8'h04);
    io_read(PD, rd);  chk("R3 reg04 kept", rd, 8'hFF);

    // R7/R6: flags
    io_write(PI, 8'h06);
    io_write(PD, 8'h05);
    chk("R10 pulse after 06h", map_changed, 1'b1);
    @(negedge clk);
    chk("R10 pulse one cycle", map_changed, 1'b0);
    chk("R7 flags rd only", {bios_shadow_rd, bios_shadow_wr}, 2'b10);
    io_write(PD, 8'h08);
    chk("R7 flags wr only", {bios_shadow_rd, bios_shadow_wr}, 2'b01);
    chk("R6 F write only", {top_rd_int, top_wr_int}, 4'b0010);
    io_write(PI, 8'h05);
    chk("R10 no pulse for index", map_changed, 1'b0);
    io_write(PD, 8'h80);
    chk("R10 pulse after 05h", map_changed, 1'b1);
    chk("R5 seg7 write", seg_wr_int, 8'h8F);
    q_addr = 20'hDFFFF; q_write = 1'b0; #1;
    chk("R9 seg7 read external", q_internal, 1'b0);
    q_write = 1'b1; #1;
    chk("R9 seg7 write internal", q_internal, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule